// File: doc/BRIEF.md
# Maskable Digital I/O Port with Edge Interrupts

This block is one bank of general-purpose digital pins. Each pin has a direction bit and an output latch, and the pin level is brought back into the clock domain through a synchronizer. Software changes the latch in one of three ways: it writes the latch directly, it writes ones to a set register to raise bits, or it writes ones to a clear register to lower them. A shield register protects chosen bits. Shielded bits keep their latch value through all three kinds of write, and they read as zero from the pin register. This lets one driver update a field of the port without a read-modify-write that could disturb pins owned by other code.

Every pin also has an edge detector. Rising and falling transitions are recorded in two separate status registers. Two per-pin enable registers decide which recorded edges reach the single interrupt line. Status bits stay set until software writes ones to an edge-clear register. The register bus is a word-indexed write strobe with byte-lane enables, so byte, halfword and word writes all work. Read data is a combinational function of the address.

Top module: `pio_bank`

## Requirements
- R1: After reset the direction, shield, latch, both enable and both status registers are zero. So `pad_oe` and `pad_out` are zero, `irq` is low, and every pin is an input.
- R2: Writing word 4 (set) drives high each latch bit whose written bit is 1. Writing word 5 (clear) drives those bits low. Bits written as 0 keep their value.
- R3: A bit that is 1 in the shield register (word 1) keeps its latch value through writes to the latch (word 2), set (word 4) and clear (word 5) registers.
- R4: Reading word 3 returns the synchronized pin levels ANDed with the inverse of the shield register. A pin change made before a clock edge appears on the read after the second rising edge, and not after the first.
- R5: Word 0 holds direction, where 1 means output, and `pad_oe` mirrors it. Word 2 reads back the full latch with no shielding applied.
- R6: Byte-lane enable bit i gates data bits 8i+7 down to 8i on every writable register, including set, clear and edge-clear. Bits in lanes that are not enabled are unchanged.
- R7: A rising pin transition sets its bit in word 8, and a falling one sets its bit in word 9. The bit is set on the third rising edge after the change, whether or not the edge is enabled.
- R8: `irq` is high exactly when some bit is set in both word 8 and the rise enable (word 6), or in both word 9 and the fall enable (word 7). It stays high until a write changes that condition.
- R9: Writing ones to word 10 clears the matching bits in both status registers. If an edge on a bit is detected in the same cycle as the clear, the edge wins and the bit stays set.
- R10: A pin held high across reset release records no rising edge.
- R11: Reads of words 4, 5 and 10 and of unmapped words 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_in | input | WIDTH | Asynchronous pin levels |
| pad_out | output | WIDTH | Output latch value driven to the pads |
| pad_oe | output | WIDTH | Per-pin output enable (direction) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word index of the register |
| bus_be | input | WIDTH/8 | Byte-lane write enables |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| irq | output | 1 | Port interrupt request |

## Verification
Register writes take effect at the clock edge that samples the strobe. The bench drives every write at a falling edge and reads one falling edge later, after that capture edge. Read data and `irq` are combinational, so they are sampled a moment after the address is set. A pin change reaches the pin register after two rising edges and the status registers after three. The bench checks the value both before and at those edges. The clear-versus-edge case is timed so that the clear strobe lands on the same edge that records the transition.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;

   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_DIR   = 4'd0,
      REG_SHLD  = 4'd1,
      REG_LAT   = 4'd2,
      REG_PIN   = 4'd3,
      REG_SET   = 4'd4,
      REG_CLR   = 4'd5,
      REG_REN   = 4'd6,
      REG_FEN   = 4'd7,
      REG_RST   = 4'd8,
      REG_FST   = 4'd9,
      REG_ECLR  = 4'd10
   } pio_reg_e;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_bank_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int LANES = WIDTH / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [LANES-1:0]  bus_be,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  shld_q,
   output logic [WIDTH-1:0]  lat_q,
   output logic [WIDTH-1:0]  ren_q,
   output logic [WIDTH-1:0]  fen_q,
   output logic [WIDTH-1:0]  eclr
);

   logic [WIDTH-1:0] lane_bits;
   logic [WIDTH-1:0] lat_bits;
   logic [WIDTH-1:0] wd_lane;
   logic [WIDTH-1:0] wd_lat;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_bits[8*l +: 8] = {8{bus_be[l]}};
   end

   assign lat_bits = lane_bits & ~shld_q;
   assign wd_lane  = bus_wdata & lane_bits;
   assign wd_lat   = bus_wdata & lat_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q  <= '0;
         shld_q <= '0;
         lat_q  <= '0;
         ren_q  <= '0;
         fen_q  <= '0;
      end else if (bus_wr) begin
         case (pio_reg_e'(bus_addr))
            REG_DIR:  dir_q  <= (dir_q  & ~lane_bits) | wd_lane;
            REG_SHLD: shld_q <= (shld_q & ~lane_bits) | wd_lane;
            REG_LAT:  lat_q  <= (lat_q  & ~lat_bits)  | wd_lat;
            REG_SET:  lat_q  <= lat_q | wd_lat;
            REG_CLR:  lat_q  <= lat_q & ~wd_lat;
            REG_REN:  ren_q  <= (ren_q  & ~lane_bits) | wd_lane;
            REG_FEN:  fen_q  <= (fen_q  & ~lane_bits) | wd_lane;
            default: ;
         endcase
      end
   end

   assign eclr = (bus_wr && pio_reg_e'(bus_addr) == REG_ECLR) ? wd_lane : '0;

endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2,
   localparam int CNT_W = $clog2(STAGES + 2)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] pin_s,
   input  logic [WIDTH-1:0] eclr,
   input  logic [WIDTH-1:0] ren,
   input  logic [WIDTH-1:0] fen,
   output logic [WIDTH-1:0] rise_st,
   output logic [WIDTH-1:0] fall_st,
   output logic             irq
);

   logic [WIDTH-1:0] prev_q;
   logic [CNT_W-1:0] settle_q;
   logic             armed;
   logic [WIDTH-1:0] rise_hit;
   logic [WIDTH-1:0] fall_hit;

   // Detection waits until the synchronizer and the history flop hold real pin data.
   assign armed = (settle_q == CNT_W'(STAGES + 1));

   always_ff @(posedge clk) begin
      if (rst)         settle_q <= '0;
      else if (!armed) settle_q <= settle_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= pin_s;
   end

   assign rise_hit = armed ? ( pin_s & ~prev_q) : '0;
   assign fall_hit = armed ? (~pin_s &  prev_q) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         rise_st <= '0;
         fall_st <= '0;
      end else begin
         rise_st <= (rise_st & ~eclr) | rise_hit;
         fall_st <= (fall_st & ~eclr) | fall_hit;
      end
   end

   assign irq = |((rise_st & ren) | (fall_st & fen));

endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_bank_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2,
   localparam int LANES = WIDTH / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [LANES-1:0]  bus_be,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              irq
);

   if (WIDTH < 8 || WIDTH % 8 != 0) begin : g_bad_width
      $error("pio_bank: WIDTH must be a positive multiple of 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_bank: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] shld_q;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] ren_q;
   logic [WIDTH-1:0] fen_q;
   logic [WIDTH-1:0] eclr;
   logic [WIDTH-1:0] pin_s;
   logic [WIDTH-1:0] rise_st;
   logic [WIDTH-1:0] fall_st;

   pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pad_in),
      .q   (pin_s)
   );

   pio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .dir_q     (dir_q),
      .shld_q    (shld_q),
      .lat_q     (lat_q),
      .ren_q     (ren_q),
      .fen_q     (fen_q),
      .eclr      (eclr)
   );

   pio_edge #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .pin_s   (pin_s),
      .eclr    (eclr),
      .ren     (ren_q),
      .fen     (fen_q),
      .rise_st (rise_st),
      .fall_st (fall_st),
      .irq     (irq)
   );

   always_comb begin
      case (pio_reg_e'(bus_addr))
         REG_DIR:  bus_rdata = dir_q;
         REG_SHLD: bus_rdata = shld_q;
         REG_LAT:  bus_rdata = lat_q;
         REG_PIN:  bus_rdata = pin_s & ~shld_q;
         REG_REN:  bus_rdata = ren_q;
         REG_FEN:  bus_rdata = fen_q;
         REG_RST:  bus_rdata = rise_st;
         REG_FST:  bus_rdata = fall_st;
         default:  bus_rdata = '0;
      endcase
   end

   assign pad_out = lat_q;
   assign pad_oe  = dir_q;

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
   import pio_bank_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  shld_q,
   input logic              irq
);

   assert_set_only_raises_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == REG_SET) |=> ((pad_out & $past(pad_out)) == $past(pad_out)));

   assert_clr_only_lowers_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == REG_CLR) |=> ((pad_out | $past(pad_out)) == $past(pad_out)));

   assert_shield_guard_R3: assert property (@(posedge clk) disable iff (rst)
      (((pad_out ^ $past(pad_out)) & $past(shld_q)) == '0));

   assert_dir_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && bus_addr == REG_DIR) |=> $stable(pad_oe));

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (irq && !bus_wr) |=> irq);

endmodule

bind pio_bank pio_bank_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .shld_q   (shld_q),
   .irq      (irq)
);

// File: tb/pio_bank_tb.sv
`timescale 1ns/1ps
module pio_bank_tb;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  pad_in = 32'h0000_0001;
   logic [W-1:0]  pad_out;
   logic [W-1:0]  pad_oe;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = 4'd0;
   logic [3:0]    bus_be = 4'hF;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pio_bank u_dut (
      .clk       (clk),
      .rst       (rst),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   localparam logic [3:0] A_DIR = 4'd0, A_SHLD = 4'd1, A_LAT = 4'd2, A_PIN = 4'd3,
                          A_SET = 4'd4, A_CLR = 4'd5, A_REN = 4'd6, A_FEN = 4'd7,
                          A_RST = 4'd8, A_FST = 4'd9, A_ECLR = 4'd10;

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [W-1:0] d);
      bus_addr  = a;
      bus_be    = be;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_be    = 4'hF;
   endtask

   task automatic chk_reg(input string tag, input logic [3:0] a, input logic [W-1:0] exp);
      bus_addr = a;
      #0.5;
      check(tag, bus_rdata, exp);
   endtask

   task automatic t_reset;
      step(6);
      check("R1 pad_oe", pad_oe, '0);
      check("R1 pad_out", pad_out, '0);
      check("R1 irq", {31'd0, irq}, '0);
      chk_reg("R1 dir", A_DIR, '0);
      chk_reg("R1 shield", A_SHLD, '0);
      chk_reg("R10 rise status after high pin", A_RST, '0);
      chk_reg("R10 fall status", A_FST, '0);
      chk_reg("R4 pin reads high bit", A_PIN, 32'h0000_0001);
   endtask

   task automatic t_set_clr;
      wr(A_DIR, 4'hF, 32'hFFFF_FFFF);
      check("R5 pad_oe from dir", pad_oe, 32'hFFFF_FFFF);
      wr(A_SET, 4'hF, 32'h0000_00F0);
      check("R2 set F0", pad_out, 32'h0000_00F0);
      wr(A_SET, 4'hF, 32'h0000_0003);
      check("R2 set keeps zeros", pad_out, 32'h0000_00F3);
      wr(A_CLR, 4'hF, 32'h0000_0030);
      check("R2 clear 30", pad_out, 32'h0000_00C3);
      chk_reg("R5 latch read", A_LAT, 32'h0000_00C3);
   endtask

   task automatic t_shield;
      wr(A_LAT, 4'hF, 32'h0000_5A00);
      wr(A_SHLD, 4'hF, 32'h0000_FF00);
      wr(A_LAT, 4'hF, 32'hFFFF_FFFF);
      check("R3 latch write shielded", pad_out, 32'hFFFF_5AFF);
      wr(A_CLR, 4'hF, 32'hFFFF_FFFF);
      check("R3 clear shielded", pad_out, 32'h0000_5A00);
      wr(A_SET, 4'hF, 32'hFFFF_FFFF);
      check("R3 set shielded", pad_out, 32'hFFFF_5AFF);
      chk_reg("R5 latch read unshielded", A_LAT, 32'hFFFF_5AFF);
      wr(A_SHLD, 4'hF, 32'h0);
   endtask

   task automatic t_pin;
      pad_in = 32'h0;
      step(3);
      pad_in = 32'hA5A5_0F0F;
      step(1);
      chk_reg("R4 pin after one edge", A_PIN, 32'h0);
      step(1);
      chk_reg("R4 pin after two edges", A_PIN, 32'hA5A5_0F0F);
      wr(A_SHLD, 4'hF, 32'h0000_FFFF);
      chk_reg("R4 pin shielded reads zero", A_PIN, 32'hA5A5_0000);
      wr(A_SHLD, 4'hF, 32'h0);
   endtask

   task automatic t_lanes;
      wr(A_LAT, 4'hF, 32'h0);
      wr(A_LAT, 4'b0010, 32'h1122_3344);
      check("R6 latch lane1", pad_out, 32'h0000_3300);
      wr(A_SET, 4'b1100, 32'hFFFF_FFFF);
      check("R6 set upper half", pad_out, 32'hFFFF_3300);
      wr(A_CLR, 4'b0100, 32'hFFFF_FFFF);
      check("R6 clear lane2", pad_out, 32'hFF00_3300);
      wr(A_DIR, 4'b0001, 32'h0000_00AA);
      check("R6 dir lane0", pad_oe, 32'hFFFF_FFAA);
   endtask

   task automatic t_edges;
      pad_in = 32'h0;
      step(4);
      wr(A_REN, 4'hF, 32'h0);
      wr(A_FEN, 4'hF, 32'h0);
      wr(A_ECLR, 4'hF, 32'hFFFF_FFFF);
      chk_reg("R9 status cleared", A_RST, 32'h0);
      pad_in[3] = 1'b1;
      step(2);
      chk_reg("R7 rise not yet", A_RST, 32'h0);
      step(1);
      chk_reg("R7 rise at third edge", A_RST, 32'h0000_0008);
      check("R8 irq off while disabled", {31'd0, irq}, '0);
      wr(A_REN, 4'hF, 32'h0000_0008);
      check("R8 irq on enable", {31'd0, irq}, 32'd1);
      pad_in[3] = 1'b0;
      step(3);
      chk_reg("R7 fall status", A_FST, 32'h0000_0008);
      wr(A_ECLR, 4'b0001, 32'h0000_0008);
      chk_reg("R9 clear rise", A_RST, 32'h0);
      chk_reg("R9 clear fall", A_FST, 32'h0);
      check("R8 irq off after clear", {31'd0, irq}, '0);
      wr(A_FEN, 4'hF, 32'h0000_0010);
      pad_in[4] = 1'b1;
      step(3);
      chk_reg("R7 rise bit4", A_RST, 32'h0000_0010);
      check("R8 irq ignores rise without enable", {31'd0, irq}, '0);
      pad_in[4] = 1'b0;
      step(3);
      check("R8 irq on enabled fall", {31'd0, irq}, 32'd1);
      wr(A_ECLR, 4'hF, 32'hFFFF_FFFF);
      wr(A_REN, 4'hF, 32'h0);
      wr(A_FEN, 4'hF, 32'h0);
   endtask

   task automatic t_race;
      pad_in[6] = 1'b1;
      step(2);
      wr(A_ECLR, 4'hF, 32'h0000_0040);
      chk_reg("R9 edge beats clear", A_RST, 32'h0000_0040);
      wr(A_ECLR, 4'hF, 32'h0000_0040);
      chk_reg("R9 later clear works", A_RST, 32'h0);
   endtask

   task automatic t_unmapped;
      chk_reg("R11 set reads zero", A_SET, 32'h0);
      chk_reg("R11 clear reads zero", A_CLR, 32'h0);
      chk_reg("R11 edge clear reads zero", A_ECLR, 32'h0);
      for (int a = 11; a < 16; a++) chk_reg("R11 unmapped", 4'(a), 32'h0);
   endtask

   initial begin
      step(3);
      rst = 1'b0;
      t_reset;
      t_set_clr;
      t_shield;
      t_pin;
      t_lanes;
      t_edges;
      t_race;
      t_unmapped;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule